// File: doc/BRIEF.md
# Calibration Cycle Sequencer with Lower-Half Output Hold

This block handles the digital timing of the self-calibration cycles in a two-stage 10-bit converter's output path. Calibration is requested by an active-low pulse. A mode select picks where the pulse comes from: an on-chip generator (used for the start-up and periodic modes) or a pin driven from outside. The selected pulse passes through a two-flop synchronizer. Each falling edge then starts a unit cycle of fixed length, and the block reports that cycle on a busy flag.

The fine comparator is lent to the calibration logic near the end of each unit cycle. During that window the block freezes the five least significant bits of the registered output word. The five most significant bits keep following fresh conversion results. The block also counts unit cycles. After every seventh cycle it emits a one-clock strobe marking a finished calibration process, and its count starts again from zero.

Top module: `calseq_top`

## Requirements
- R1: A falling edge on the selected calibration input starts a unit cycle. With the input first sampled low at rising edge E0, `busy` is high after edge E2, which is two synchronizer stages plus one register.
- R2: `busy` stays high for exactly 7 consecutive clock cycles per unit cycle, then drops.
- R3: `dout[9:5]` always equals `din[9:5]` as sampled at the previous rising edge, including during a unit cycle.
- R4: `dout[4:0]` normally equals `din[4:0]` from the previous edge. It is not updated on the last 4 edges of a unit cycle: with `busy` rising after E2, it keeps the value captured at E5 through E9 and follows `din` again from E10.
- R5: `mode_sel` 2'b10 selects `cal_ext_n`. The codes 2'b00, 2'b01 and 2'b11 select `cal_int_n`. Edges on the input that is not selected have no effect.
- R6: `proc_done` is high for one clock, in the cycle where `busy` falls at the end of the 7th unit cycle since reset or since the last strobe. The unit count then restarts from zero.
- R7: A falling edge that arrives while `busy` is high is ignored. It neither restarts nor lengthens the cycle, and it is not counted as a unit cycle.
- R8: Synchronous active-high `rst` clears `busy`, `proc_done`, `dout` and the unit count, and releases any hold in progress. On the first edge after release, all 10 bits of `dout` load from `din`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous reset, active high |
| cal_int_n | input | 1 | Active-low calibration pulse from the on-chip generator |
| cal_ext_n | input | 1 | Active-low calibration pulse from outside the chip |
| mode_sel | input | 2 | Calibration source mode (2'b10 external, others internal) |
| din | input | 10 | Conversion result from the converter core |
| dout | output | 10 | Registered output word, lower half held during the comparator window |
| busy | output | 1 | High while a unit calibration cycle runs |
| proc_done | output | 1 | One-clock strobe when a seven-cycle process completes |

## Verification
A cycle counter that is off by one shows within a single unit cycle. `busy` ends a clock early or late, and the frozen lower bits change one edge too soon or stay frozen one edge too long against a `din` pattern that changes every cycle. A unit-count error only shows at process granularity: the done strobe arrives one unit cycle early or late. Edges that must be ignored are therefore followed by full processes, so that any edge wrongly counted moves the strobe. A reset that leaves state behind shows on the first edge after release, as stale lower bits or a misplaced strobe seven cycles later.

// File: rtl/calseq_pkg.sv
package calseq_pkg;

  typedef enum logic [1:0] {
    MODE_STARTUP = 2'b00,
    MODE_AUTO    = 2'b01,
    MODE_EXT     = 2'b10,
    MODE_RSVD    = 2'b11
  } cal_mode_e;

  // True when a cycle position lies inside the trailing comparator window
  function automatic logic in_hold_window(input int pos, input int cyc_len, input int hold_len);
    return (pos >= (cyc_len - hold_len)) && (pos < cyc_len);
  endfunction

  // True at the last position of a count that runs 0 .. len-1
  function automatic logic is_final(input int pos, input int len);
    return pos == (len - 1);
  endfunction

endpackage

// File: rtl/calseq_sync.sv
module calseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b1;
    else     chain[0] <= pin_n;
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b1;
        else     chain[g] <= chain[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= chain[STAGES-1];
  end

  assign fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/calseq_timer.sv
module calseq_timer
  import calseq_pkg::*;
#(
  parameter int CYC_LEN  = 7,
  parameter int HOLD_LEN = 4,
  parameter int UNITS    = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic fall,
  output logic busy,
  output logic hold_win,
  output logic cyc_end,
  output logic proc_done
);
  localparam int CW = $clog2(CYC_LEN + 1);
  localparam int UW = $clog2(UNITS + 1);

  logic [CW-1:0] pos_q;
  logic [UW-1:0] unit_q;
  logic          busy_q;
  logic          done_q;
  logic          unit_last;

  assign cyc_end   = busy_q && is_final(int'(pos_q), CYC_LEN);
  assign unit_last = is_final(int'(unit_q), UNITS);
  assign hold_win  = busy_q && in_hold_window(int'(pos_q), CYC_LEN, HOLD_LEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
      unit_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (fall) begin
          busy_q <= 1'b1;
          pos_q  <= '0;
        end
      end else if (cyc_end) begin
        busy_q <= 1'b0;
        pos_q  <= '0;
        if (unit_last) begin
          unit_q <= '0;
          done_q <= 1'b1;
        end else begin
          unit_q <= unit_q + 1'b1;
        end
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign busy      = busy_q;
  assign proc_done = done_q;
endmodule

// File: rtl/calseq_hold.sv
module calseq_hold #(
  parameter int DW    = 10,
  parameter int LOW_W = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  logic [DW-LOW_W-1:0] hi_q;
  logic [LOW_W-1:0]    lo_q;

  always_ff @(posedge clk) begin
    if (rst) hi_q <= '0;
    else     hi_q <= din[DW-1:LOW_W];
  end

  always_ff @(posedge clk) begin
    if (rst)        lo_q <= '0;
    else if (!hold) lo_q <= din[LOW_W-1:0];
  end

  assign dout = {hi_q, lo_q};
endmodule

// File: rtl/calseq_top.sv
module calseq_top
  import calseq_pkg::*;
#(
  parameter int DW          = 10,
  parameter int LOW_W       = 5,
  parameter int CYC_LEN     = 7,
  parameter int HOLD_LEN    = 4,
  parameter int UNITS       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cal_int_n,
  input  logic          cal_ext_n,
  input  logic [1:0]    mode_sel,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          busy,
  output logic          proc_done
);
  logic pin_sel_n;
  logic fall_evt;
  logic hold_win;
  logic cyc_end;

  assign pin_sel_n = (mode_sel == MODE_EXT) ? cal_ext_n : cal_int_n;

  calseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pin_n (pin_sel_n),
    .fall  (fall_evt)
  );

  calseq_timer #(.CYC_LEN(CYC_LEN), .HOLD_LEN(HOLD_LEN), .UNITS(UNITS)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .fall      (fall_evt),
    .busy      (busy),
    .hold_win  (hold_win),
    .cyc_end   (cyc_end),
    .proc_done (proc_done)
  );

  calseq_hold #(.DW(DW), .LOW_W(LOW_W)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .hold (hold_win),
    .din  (din),
    .dout (dout)
  );
endmodule

// File: rtl/calseq_checker.sv
module calseq_checker #(
  parameter int DW      = 10,
  parameter int LOW_W   = 5,
  parameter int CYC_LEN = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          proc_done,
  input logic          fall_evt,
  input logic          hold_win,
  input logic          cyc_end,
  input logic [DW-1:0] din,
  input logic [DW-1:0] dout
);
  int run_cnt;

  always_ff @(posedge clk) begin
    if (rst)       run_cnt <= 0;
    else if (busy) run_cnt <= run_cnt + 1;
    else           run_cnt <= 0;
  end

  p_busy_start_r1: assert property (@(posedge clk) disable iff (rst)
    fall_evt && !busy |=> busy);

  p_no_extend_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> run_cnt < CYC_LEN);

  p_busy_full_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) && !$past(rst) |-> run_cnt == CYC_LEN);

  p_end_drops_r2: assert property (@(posedge clk) disable iff (rst)
    cyc_end |=> !busy);

  p_hi_track_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> dout[DW-1:LOW_W] == $past(din[DW-1:LOW_W]));

  p_lo_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    hold_win |=> $stable(dout[LOW_W-1:0]));

  p_lo_track_r4: assert property (@(posedge clk) disable iff (rst)
    !hold_win |=> dout[LOW_W-1:0] == $past(din[LOW_W-1:0]));

  p_done_at_end_r6: assert property (@(posedge clk) disable iff (rst)
    proc_done |-> $fell(busy));

  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    proc_done |=> !proc_done);
endmodule

bind calseq_top calseq_checker #(.DW(DW), .LOW_W(LOW_W), .CYC_LEN(CYC_LEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .proc_done (proc_done),
  .fall_evt  (fall_evt),
  .hold_win  (hold_win),
  .cyc_end   (cyc_end),
  .din       (din),
  .dout      (dout)
);

// File: tb/calseq_top_bench.sv
`timescale 1ns/1ps
module calseq_top_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cal_int_n = 1'b1;
  logic       cal_ext_n = 1'b1;
  logic [1:0] mode_sel = 2'b00;
  logic [9:0] din = '0;
  logic [9:0] dout;
  logic       busy;
  logic       proc_done;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  calseq_top u_calseq_top (
    .clk(clk), .rst(rst), .cal_int_n(cal_int_n), .cal_ext_n(cal_ext_n),
    .mode_sel(mode_sel), .din(din), .dout(dout), .busy(busy), .proc_done(proc_done)
  );

  function automatic logic [9:0] pat(input int seed, input int k);
    return 10'((seed * 97 + k * 37 + 5) % 1024);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_pin(input bit use_ext, input logic v);
    if (use_ext) cal_ext_n = v;
    else         cal_int_n = v;
  endtask

  task automatic step(input logic [9:0] d);
    @(negedge clk);
    din = d;
    @(posedge clk);
    #1;
  endtask

  // One unit cycle: pin sampled low at E0, checks after each edge Ek.
  task automatic run_unit(input logic [1:0] mode, input bit exp_done, input int intrude, input int seed);
    bit use_ext;
    use_ext = (mode == 2'b10);
    @(negedge clk);
    mode_sel = mode;
    for (int k = 0; k <= 12; k++) begin
      @(negedge clk);
      din = pat(seed, k);
      if (k == 0) set_pin(use_ext, 1'b0);
      if (k == 3) set_pin(use_ext, 1'b1);
      if (k == intrude) set_pin(use_ext, 1'b0);
      if (k == intrude + 2) set_pin(use_ext, 1'b1);
      @(posedge clk);
      #1;
      if (k == 2)
        check("R1 busy rises after E2", int'(busy), 1);
      else if (intrude >= 0)
        check("R7 busy ignores edge while busy", int'(busy), int'(k >= 2 && k <= 8));
      else
        check("R2 busy length", int'(busy), int'(k >= 2 && k <= 8));
      check("R6 done strobe", int'(proc_done), int'(k == 9 && exp_done));
      check("R3 upper bits track", int'(dout[9:5]), int'(pat(seed, k) >> 5));
      if (k >= 6 && k <= 9)
        check("R4 lower bits held", int'(dout[4:0]), int'(pat(seed, 5) & 10'h1f));
      else
        check("R4 lower bits track", int'(dout[4:0]), int'(pat(seed, k) & 10'h1f));
    end
  endtask

  task automatic test_reset_state();
    rst = 1'b1;
    din = 10'h3ff;
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset busy", int'(busy), 0);
    check("R8 reset done", int'(proc_done), 0);
    check("R8 reset dout", int'(dout), 0);
    @(negedge clk);
    rst = 1'b0;
    step(10'h2a5);
    check("R8 first load after reset", int'(dout), 10'h2a5);
  endtask

  task automatic test_unselected_ignored();
    @(negedge clk);
    mode_sel = 2'b10;
    for (int k = 0; k <= 12; k++) begin
      @(negedge clk);
      din = pat(50, k);
      if (k == 0 || k == 6) cal_int_n = 1'b0;
      if (k == 3 || k == 8) cal_int_n = 1'b1;
      @(posedge clk);
      #1;
      check("R5 unselected input ignored busy", int'(busy), 0);
      check("R5 unselected input full dout", int'(dout), int'(pat(50, k)));
    end
  endtask

  task automatic test_mid_reset(input int seed);
    @(negedge clk);
    mode_sel = 2'b00;
    for (int k = 0; k <= 6; k++) begin
      @(negedge clk);
      din = pat(seed, k);
      if (k == 0) cal_int_n = 1'b0;
      if (k == 3) cal_int_n = 1'b1;
      @(posedge clk);
      #1;
    end
    check("R4 hold active before reset", int'(dout[4:0]), int'(pat(seed, 5) & 10'h1f));
    @(negedge clk);
    rst = 1'b1;
    din = pat(seed, 7);
    @(posedge clk);
    #1;
    check("R8 mid reset busy", int'(busy), 0);
    check("R8 mid reset dout", int'(dout), 0);
    @(negedge clk);
    rst = 1'b0;
    din = pat(seed, 8);
    @(posedge clk);
    #1;
    check("R8 hold released full load", int'(dout), int'(pat(seed, 8)));
    check("R8 busy stays low", int'(busy), 0);
    repeat (4) step(pat(seed, 9));
  endtask

  initial begin : watchdog
    #500000;
    n_checks++;
    n_fails++;
    $display("FAIL R2 watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    test_reset_state();
    // First process: internal sources for startup, auto, then external.
    for (int u = 1; u <= 3; u++) run_unit(2'b00, 1'b0, -1, u);
    for (int u = 4; u <= 6; u++) run_unit(2'b01, 1'b0, -1, u);
    run_unit(2'b10, 1'b1, -1, 7);
    // Second process: an edge inside a busy cycle and unselected edges must not count.
    run_unit(2'b11, 1'b0, 5, 8);
    test_unselected_ignored();
    for (int u = 2; u <= 6; u++) run_unit(2'b10, 1'b0, -1, 10 + u);
    run_unit(2'b10, 1'b1, -1, 20);
    // Partial process cut by reset; the count must restart at zero.
    for (int u = 1; u <= 3; u++) run_unit(2'b00, 1'b0, -1, 30 + u);
    test_mid_reset(40);
    for (int u = 1; u <= 6; u++) run_unit(2'b01, 1'b0, -1, 50 + u);
    run_unit(2'b01, 1'b1, -1, 60);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule